// File: doc/BRIEF.md
# Four-Neighbour Relaxation Stencil Engine

This block runs repeated relaxation sweeps over a two-dimensional grid of unsigned values. The grid sits in on-chip storage. During a sweep the engine reads it once, in row-major order, as a single stream. Line-buffer taps on that stream supply each centre point with its four orthogonal neighbours. Every interior point is replaced by the integer mean of those four neighbours, and every point on the outer ring keeps its value. The new grid becomes the input of the next sweep, and the engine runs as many sweeps as the caller requests.

The engine has two storage banks used as a ping-pong pair. One bank is the source and the other is the destination. They swap roles when a sweep ends, so no copy pass is needed between sweeps. Before a run, the grid is loaded through a write port that uses a valid/ready handshake. The load port applies back-pressure by holding ld_ready low for the whole run; a word offered while ld_ready is low is dropped and never stored. After done, the result is read back through a read port with a one-cycle latency. A run begins with a one-cycle start pulse and ends with a one-cycle done pulse.

Top module: `relax_engine`

## Requirements
- R1: The new value of each interior point (row 1..NROWS-2, column 1..NCOLS-2) is floor((north+south+east+west)/4). The sum is formed without overflow, so a grid of all-ones values (2^18-1 each) stays at 2^18-1.
- R2: Points in row 0, row NROWS-1, column 0 or column NCOLS-1 leave every sweep with their value unchanged.
- R3: Each sweep reads only the previous sweep's complete output, with no in-place update. After k sweeps the grid equals k independent applications of the R1/R2 step.
- R4: A start with iter_count 0 leaves the grid unchanged, never raises busy, and gives done in the cycle after the start edge.
- R5: When start is sampled with a nonzero iter_count K, busy rises after that edge. done is a single-cycle pulse, high in the cycle after the edge that lies K*(NROWS*NCOLS+NCOLS+2) edges after the start edge. busy is low while done is high.
- R6: ld_ready is high exactly when the engine is idle. A word offered with ld_valid while busy is not stored, and the result is the same as without it.
- R7: A start pulse seen while busy is ignored. The running job neither restarts nor lengthens.
- R8: When idle, rb_data gives, one cycle after rb_addr is applied, the word at that address of the current grid: the loaded grid, or the result of the last run.
- R9: Address a holds row a/NCOLS, column a%NCOLS. North and south are the points one row up and one row down, and west and east are the points one column left and one column right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled only when idle |
| iter_count | input | IW | Number of sweeps for this run |
| busy | output | 1 | High while sweeps are in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| ld_valid | input | 1 | Load word is offered |
| ld_ready | output | 1 | Load accepted this cycle (idle) |
| ld_addr | input | AW | Grid address of the load word |
| ld_data | input | DW | Load word |
| rb_addr | input | AW | Read-back address |
| rb_data | output | DW | Read-back word, one cycle after rb_addr |

## Verification
A centre-address or tap-offset error shows up in the read-back grid as a plain mismatch after a single sweep. This is clearest with an impulse grid, where the four nonzero neighbours land at the wrong addresses. A wrong border decision shows at the ring positions, also after one sweep. A sequencing fault, such as a lost bank swap, an unflushed stream counter or a miscounted iteration, changes the exact cycle of the done pulse, so it is seen within the run itself. A bank-swap error can also leave a multi-sweep result equal to an earlier sweep, which the three-sweep comparison exposes.

// File: rtl/relax_pkg.sv
package relax_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } relax_state_e;

endpackage

// File: rtl/relax_bank.sv
module relax_bank #(
  parameter int DW    = 18,
  parameter int DEPTH = 120,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/relax_taps.sv
module relax_taps #(
  parameter int DW    = 18,
  parameter int NCOLS = 10
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] tap_n,
  output logic [DW-1:0] tap_e,
  output logic [DW-1:0] tap_c,
  output logic [DW-1:0] tap_w,
  output logic [DW-1:0] tap_s
);

  localparam int DEPTH = 2 * NCOLS;

  // hist[d] holds the element d+1 positions behind the newest one
  logic [DW-1:0] hist [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    if (i == 0) begin : g_head
      always_ff @(posedge clk) if (shift_en) hist[0] <= din;
    end else begin : g_body
      always_ff @(posedge clk) if (shift_en) hist[i] <= hist[i-1];
    end
  end

  // newest element is the south neighbour of the centre NCOLS behind it
  assign tap_s = din;
  assign tap_e = hist[NCOLS-2];
  assign tap_c = hist[NCOLS-1];
  assign tap_w = hist[NCOLS];
  assign tap_n = hist[DEPTH-1];

endmodule

// File: rtl/relax_kernel.sv
module relax_kernel #(
  parameter int DW    = 18,
  parameter int NROWS = 12,
  parameter int NCOLS = 10,
  parameter int CW    = 10,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [AW-1:0] centre_addr,
  input  logic [DW-1:0] tap_n,
  input  logic [DW-1:0] tap_e,
  input  logic [DW-1:0] tap_c,
  input  logic [DW-1:0] tap_w,
  input  logic [DW-1:0] tap_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int SW = DW + 2;

  logic [CW-1:0] row, col;
  logic          on_ring;
  logic [SW-1:0] hsum_q, vsum_q, total;
  logic [DW-1:0] ctr_q;
  logic          ring_q;
  logic          v_q;
  logic [AW-1:0] addr_q;

  assign on_ring = (row == '0) || (row == CW'(NROWS-1)) ||
                   (col == '0) || (col == CW'(NCOLS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= win_valid;
      if (win_valid) begin
        if (col == CW'(NCOLS-1)) begin
          col <= '0;
          row <= (row == CW'(NROWS-1)) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (win_valid) begin
      hsum_q <= SW'(tap_e) + SW'(tap_w);
      vsum_q <= SW'(tap_n) + SW'(tap_s);
      ctr_q  <= tap_c;
      ring_q <= on_ring;
      addr_q <= centre_addr;
    end
  end

  assign total   = hsum_q + vsum_q;
  assign wr_en   = v_q;
  assign wr_addr = addr_q;
  assign wr_data = ring_q ? ctr_q : total[SW-1:2];

endmodule

// File: rtl/relax_seq.sv
module relax_seq
  import relax_pkg::*;
#(
  parameter int NROWS = 12,
  parameter int NCOLS = 10,
  parameter int AW    = 7,
  parameter int IW    = 8,
  parameter int KW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] iter_count,
  input  logic          last_write,
  output logic          busy,
  output logic          done,
  output logic          src_sel,
  output logic [AW-1:0] rd_addr,
  output logic          shift_en,
  output logic          win_valid,
  output logic [AW-1:0] centre_addr
);

  localparam int N     = NROWS * NCOLS;
  localparam int KLAST = N + NCOLS;

  relax_state_e  state;
  logic [KW-1:0] rd_k, k_q;
  logic [IW-1:0] left;
  logic          v_q;
  logic          issue;

  assign issue       = (state == ST_SWEEP) && (rd_k < KW'(KLAST));
  assign rd_addr     = (rd_k < KW'(N)) ? AW'(rd_k) : '0;
  assign busy        = (state == ST_SWEEP);
  assign shift_en    = v_q;
  assign win_valid   = v_q && (k_q >= KW'(NCOLS));
  assign centre_addr = AW'(k_q - KW'(NCOLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rd_k    <= '0;
      k_q     <= '0;
      v_q     <= 1'b0;
      left    <= '0;
      src_sel <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      v_q  <= issue;
      k_q  <= rd_k;
      if (issue) rd_k <= rd_k + 1'b1;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (iter_count == '0) begin
              done <= 1'b1;
            end else begin
              left  <= iter_count;
              rd_k  <= '0;
              state <= ST_SWEEP;
            end
          end
        end
        ST_SWEEP: begin
          if (last_write) begin
            src_sel <= ~src_sel;
            if (left == IW'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              left <= left - 1'b1;
              rd_k <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/relax_engine.sv
module relax_engine #(
  parameter int NROWS = 12,
  parameter int NCOLS = 10,
  parameter int DW    = 18,
  parameter int CW    = 10,
  parameter int IW    = 8,
  parameter int AW    = $clog2(NROWS * NCOLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] iter_count,
  output logic          busy,
  output logic          done,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  localparam int N  = NROWS * NCOLS;
  localparam int KW = $clog2(N + NCOLS + 1);

  logic          src_sel;
  logic [AW-1:0] rd_addr;
  logic          shift_en, win_valid;
  logic [AW-1:0] centre_addr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          last_write;
  logic [DW-1:0] stream;
  logic [DW-1:0] tap_n, tap_e, tap_c, tap_w, tap_s;
  logic [DW-1:0] bank_q [2];

  assign ld_ready   = !busy;
  assign last_write = wr_en && (wr_addr == AW'(N-1));
  assign stream     = bank_q[src_sel];
  assign rb_data    = bank_q[src_sel];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata;
    assign we    = busy ? (wr_en && (src_sel != 1'(b)))
                        : (ld_valid && (src_sel == 1'(b)));
    assign waddr = busy ? wr_addr : ld_addr;
    assign wdata = busy ? wr_data : ld_data;
    assign raddr = busy ? rd_addr : rb_addr;
    relax_bank #(.DW(DW), .DEPTH(N), .AW(AW)) u_bank (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(bank_q[b])
    );
  end

  relax_seq #(.NROWS(NROWS), .NCOLS(NCOLS), .AW(AW), .IW(IW), .KW(KW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .last_write(last_write), .busy(busy), .done(done), .src_sel(src_sel),
    .rd_addr(rd_addr), .shift_en(shift_en), .win_valid(win_valid),
    .centre_addr(centre_addr)
  );

  relax_taps #(.DW(DW), .NCOLS(NCOLS)) u_taps (
    .clk(clk), .shift_en(shift_en), .din(stream),
    .tap_n(tap_n), .tap_e(tap_e), .tap_c(tap_c), .tap_w(tap_w), .tap_s(tap_s)
  );

  relax_kernel #(.DW(DW), .NROWS(NROWS), .NCOLS(NCOLS), .CW(CW), .AW(AW)) u_kernel (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .centre_addr(centre_addr),
    .tap_n(tap_n), .tap_e(tap_e), .tap_c(tap_c), .tap_w(tap_w), .tap_s(tap_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

endmodule

// File: rtl/relax_engine_chk.sv
module relax_engine_chk #(
  parameter int IW = 8,
  parameter int AW = 7,
  parameter int N  = 120
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] iter_count,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && iter_count != '0) |=> busy);

  p_zero_iter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && iter_count == '0) |=> (done && !busy));

  p_idle_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < N));

endmodule

bind relax_engine relax_engine_chk #(.IW(IW), .AW(AW), .N(NROWS * NCOLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
  .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/relax_engine_tb_top.sv
`timescale 1ns/1ps
module relax_engine_tb_top;

  localparam int NR = 12;
  localparam int NC = 10;
  localparam int N  = NR * NC;
  localparam int DW = 18;
  localparam int IW = 8;
  localparam int AW = $clog2(N);
  localparam int T  = N + NC + 2;
  localparam int MAXV = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] iter_count = '0;
  logic          busy, done;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] rb_addr = '0;
  logic [DW-1:0] rb_data;

  int n_cmp = 0;
  int n_bad = 0;
  int grid [N];

  always #2 clk = ~clk;

  relax_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .busy(busy), .done(done), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit is_ring(input int a);
    int r = a / NC;
    int c = a % NC;
    return (r == 0) || (r == NR-1) || (c == 0) || (c == NC-1);
  endfunction

  // reference step: R1 interior mean, R2 ring kept, R9 row-major neighbours
  task automatic model_step();
    int nxt [N];
    for (int a = 0; a < N; a++) begin
      if (is_ring(a)) nxt[a] = grid[a];
      else nxt[a] = (grid[a-NC] + grid[a+NC] + grid[a-1] + grid[a+1]) >> 2;
    end
    for (int a = 0; a < N; a++) grid[a] = nxt[a];
  endtask

  task automatic load_grid();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = AW'(a);
      ld_data  = DW'(grid[a]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic read_check(input string what);
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      rb_addr = AW'(a);
      @(negedge clk);
      if (is_ring(a)) check({what, " R2 ring"}, int'(rb_data), grid[a]);
      else            check({what, " R1 interior"}, int'(rb_data), grid[a]);
    end
  endtask

  // R5 timing, R6 back-pressure and R7 ignored start are checked here
  task automatic run(input int n, input bit disturb);
    int cyc = 0;
    bit got = 0;
    @(negedge clk);
    start = 1'b1;
    iter_count = IW'(n);
    while (!got && cyc < 20000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (cyc == 1 && n > 0) check("R5 busy after start", int'(busy), 1);
      if (disturb && cyc == 20) begin
        check("R6 ready low while busy", int'(ld_ready), 0);
        start = 1'b1;
        iter_count = IW'(1);
        ld_valid = 1'b1;
        ld_addr = AW'(NC + 3);
        ld_data = DW'(12345);
      end else if (disturb && cyc == 21) begin
        ld_valid = 1'b0;
      end
      if (done) got = 1;
    end
    if (!got) check("R5 watchdog no done", 0, 1);
    check(disturb ? "R7 done cycle" : "R5 done cycle", cyc, n * T + 1);
    check("R5 idle at done", int'(busy), 0);
    @(negedge clk);
    check("R5 done single pulse", int'(done), 0);
    check("R6 ready when idle", int'(ld_ready), 1);
  endtask

  task automatic t_reset();
    check("R5 reset busy", int'(busy), 0);
    check("R5 reset done", int'(done), 0);
    check("R6 reset ready", int'(ld_ready), 1);
  endtask

  task automatic t_load_read();
    for (int a = 0; a < N; a++) grid[a] = int'($urandom % (MAXV + 1));
    load_grid();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      rb_addr = AW'(a);
      @(negedge clk);
      check("R8 readback", int'(rb_data), grid[a]);
    end
  endtask

  task automatic t_zero_iter();
    run(0, 0);
    read_check("R4 unchanged");
  endtask

  task automatic t_one_sweep();
    for (int a = 0; a < N; a++) grid[a] = int'($urandom % (MAXV + 1));
    load_grid();
    run(1, 0);
    model_step();
    read_check("R1 R2 one sweep");
  endtask

  task automatic t_full_scale();
    for (int a = 0; a < N; a++) grid[a] = MAXV;
    load_grid();
    run(1, 0);
    model_step();
    read_check("R1 no overflow");
  endtask

  task automatic t_impulse();
    for (int a = 0; a < N; a++) grid[a] = 0;
    grid[3*NC + 4] = 4000;
    grid[7*NC + 1] = 8000;
    load_grid();
    run(1, 0);
    model_step();
    read_check("R9 orientation");
  endtask

  task automatic t_multi_disturbed();
    for (int a = 0; a < N; a++) grid[a] = int'($urandom % (MAXV + 1));
    load_grid();
    run(3, 1);
    for (int k = 0; k < 3; k++) model_step();
    read_check("R3 R6 R7 three sweeps");
  endtask

  initial begin
    #800000;
    check("watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_read();
    t_zero_iter();
    t_one_sweep();
    t_full_scale();
    t_impulse();
    t_multi_disturbed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule